// File: doc/BRIEF.md
# Errant-Access Default Slave

This block sits on a memory-mapped bus behind the address decoder. Every read or write whose address matches no real target is steered to it. A build-time parameter sets how it treats each such errant access. It can stall the requester forever, answer with a fixed data word, answer with a bus error code, raise a sticky interrupt, or ask the system for a reset through a stretched request pulse.

Two word locations inside the block's own span always behave as ordinary registers, whatever the mode. One holds the address of the most recent errant access. The other shows the interrupt flag and clears it. Software uses these two locations to find out which access went astray. The decoder that selects the block, and whatever acts on the reset request, sit outside it.

Top module: `errant_slave`

## Requirements
- R1: A read of the status word (word address `OWN_BASE`) completes after one wait cycle with response OKAY (2'b00) in every mode, including hang mode. It returns the captured address, zero-extended to the data width.
- R2: Outside hang mode, any access holds `waitrequest_o` high for exactly one cycle and completes in the next cycle. Errant writes discard their data. Errant reads return zero except in pattern mode.
- R3: In hang mode an errant access keeps `waitrequest_o` high for as long as the request is held, and it never completes.
- R4: In pattern mode an errant read completes with `readdata_o` equal to the `PATTERN` parameter and response OKAY. Addresses just below `OWN_BASE` and just above `OWN_BASE+1` count as errant.
- R5: In error mode an errant read or write completes with response 2'b11. Every access to the two own words completes with 2'b00.
- R6: In interrupt mode `irq_o` is high from the cycle after the first cycle of an errant access onward.
- R7: The clear word (word address `OWN_BASE+1`) reads back `irq_o` in bit 0. A write of 1 in bit 0 drops `irq_o` after the completing cycle. A write with bit 0 at 0 leaves it set.
- R8: In reset mode `rst_req_o` is high for exactly `RST_MIN_W` cycles, starting the cycle after the first cycle of an errant access. A new errant access restarts the full width.
- R9: The captured address is that of the most recent errant access in every mode, including a hang-mode access the requester abandoned. Writes to the status word do not change it.
- R10: Asserting `rst_ni` clears the captured address, `irq_o`, `rst_req_o` and any pending handshake state, and leaves `waitrequest_o`, `response_o` and `readdata_o` at zero while idle.
- R11: `irq_o` stays low in every mode except interrupt mode. `rst_req_o` stays low in every mode except reset mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| address_i | input | ADDR_W | Word address of the access |
| read_i | input | 1 | Read request, held until waitrequest_o is low |
| write_i | input | 1 | Write request, held until waitrequest_o is low |
| writedata_i | input | DATA_W | Write data |
| readdata_o | output | DATA_W | Read data, valid in the completing cycle |
| waitrequest_o | output | 1 | Stall the requester |
| response_o | output | 2 | 2'b00 OKAY, 2'b11 decode error |
| irq_o | output | 1 | Level interrupt (interrupt mode) |
| rst_req_o | output | 1 | Stretched reset request (reset mode) |

## Verification
The bench builds five copies side by side, one for each value of `MODE`. This lets every reaction, and the absence of the other modes' side effects, be checked in one run. Every copy uses a 12-bit address, a 32-bit data word and `OWN_BASE` of 0x100, so the span edges 0x0FF and 0x102 can be reached. `RST_MIN_W` is set to 5, so the full reset pulse, its end and a restart partway through all fit in a few dozen cycles.

// File: rtl/errant_pkg.sv
package errant_pkg;

  typedef enum logic [2:0] {
    ERR_HANG    = 3'd0,
    ERR_PATTERN = 3'd1,
    ERR_BUSERR  = 3'd2,
    ERR_IRQ     = 3'd3,
    ERR_RESET   = 3'd4
  } err_mode_e;

  typedef enum logic [1:0] {
    CLS_ERRANT = 2'd0,
    CLS_STATUS = 2'd1,
    CLS_CLEAR  = 2'd2
  } addr_cls_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_DECERR = 2'b11;

endpackage

// File: rtl/errant_decode.sv
module errant_decode
  import errant_pkg::*;
#(
  parameter int unsigned        ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]  OWN_BASE = '0
) (
  input  logic [ADDR_W-1:0] address_i,
  output addr_cls_e         cls_o
);

  localparam logic [ADDR_W-1:0] CLR_ADDR = OWN_BASE + ADDR_W'(1);

  always_comb begin
    if (address_i == OWN_BASE)      cls_o = CLS_STATUS;
    else if (address_i == CLR_ADDR) cls_o = CLS_CLEAR;
    else                            cls_o = CLS_ERRANT;
  end

endmodule

// File: rtl/errant_xfer.sv
module errant_xfer
  import errant_pkg::*;
#(
  parameter err_mode_e MODE = ERR_IRQ
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic errant_i,
  output logic wait_o,
  output logic first_o,
  output logic done_o
);

  localparam logic HANG_MODE = (MODE == ERR_HANG);

  logic done_q;
  logic stall;

  // errant access in hang mode never completes
  assign stall = HANG_MODE & errant_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= req_i & ~done_q & ~stall;
  end

  assign wait_o  = req_i & ~done_q;
  assign first_o = req_i & ~done_q;
  assign done_o  = req_i & done_q;

endmodule

// File: rtl/errant_irq.sv
module errant_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);

  logic irq_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= set_i | (irq_q & ~clr_i);
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/errant_stretch.sv
module errant_stretch #(
  parameter int unsigned MIN_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);

  localparam int unsigned CW = $clog2(MIN_W + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (trig_i)          cnt_q <= CW'(MIN_W);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign pulse_o = (cnt_q != '0);

endmodule

// File: rtl/errant_slave.sv
module errant_slave
  import errant_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DATA_W    = 32,
  parameter err_mode_e         MODE      = ERR_IRQ,
  parameter logic [DATA_W-1:0] PATTERN   = 32'hDEAD_C0DE,
  parameter logic [ADDR_W-1:0] OWN_BASE  = '0,
  parameter int unsigned       RST_MIN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] address_i,
  input  logic              read_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] writedata_i,
  output logic [DATA_W-1:0] readdata_o,
  output logic              waitrequest_o,
  output logic [1:0]        response_o,
  output logic              irq_o,
  output logic              rst_req_o
);

  localparam logic IRQ_MODE = (MODE == ERR_IRQ);
  localparam logic RST_MODE = (MODE == ERR_RESET);
  localparam logic PAT_MODE = (MODE == ERR_PATTERN);
  localparam logic ERR_MODE = (MODE == ERR_BUSERR);

  addr_cls_e         cls;
  logic              errant;
  logic              req;
  logic              first;
  logic              done;
  logic              err_start;
  logic              clr_hit;
  logic [ADDR_W-1:0] cap_q;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata;

  assign req = read_i | write_i;

  errant_decode #(
    .ADDR_W  (ADDR_W),
    .OWN_BASE(OWN_BASE)
  ) u_decode (
    .address_i(address_i),
    .cls_o    (cls)
  );

  assign errant = (cls == CLS_ERRANT);

  errant_xfer #(
    .MODE(MODE)
  ) u_xfer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .errant_i(errant),
    .wait_o  (waitrequest_o),
    .first_o (first),
    .done_o  (done)
  );

  assign err_start = first & errant;
  assign clr_hit   = done & write_i & (cls == CLS_CLEAR) & writedata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cap_q <= '0;
    else if (err_start) cap_q <= address_i;
  end

  errant_irq u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (IRQ_MODE & err_start),
    .clr_i (clr_hit),
    .irq_o (irq_o)
  );

  errant_stretch #(
    .MIN_W(RST_MIN_W)
  ) u_stretch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (RST_MODE & err_start),
    .pulse_o(rst_req_o)
  );

  always_comb begin
    unique case (cls)
      CLS_STATUS: rd_mux = DATA_W'(cap_q);
      CLS_CLEAR:  rd_mux = DATA_W'(irq_o);
      default:    rd_mux = PAT_MODE ? PATTERN : '0;
    endcase
  end

  assign readdata_o   = (done & read_i) ? rd_mux : '0;
  assign response_o   = (done & errant & ERR_MODE) ? RESP_DECERR : RESP_OKAY;
  assign unused_wdata = ^writedata_i[DATA_W-1:1];

endmodule

// File: rtl/errant_slave_chk.sv
module errant_slave_chk
  import errant_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter err_mode_e         MODE      = ERR_IRQ,
  parameter logic [ADDR_W-1:0] OWN_BASE  = '0,
  parameter int unsigned       RST_MIN_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] address_i,
  input logic              read_i,
  input logic              write_i,
  input logic              clr_bit_i,
  input logic              errant_i,
  input logic              waitrequest_o,
  input logic [1:0]        response_o,
  input logic              irq_o,
  input logic              rst_req_o
);

  localparam logic [ADDR_W-1:0] CLR_ADDR = OWN_BASE + ADDR_W'(1);

  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= 0;
    else if (rst_req_o) run_q <= run_q + 1;
    else                run_q <= 0;
  end

  // R2
  wait_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE != ERR_HANG && waitrequest_o) |=> !waitrequest_o);

  // R2
  wait_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waitrequest_o |-> (read_i || write_i));

  // R3
  hang_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == ERR_HANG && (read_i || write_i) && errant_i) |-> waitrequest_o);

  // R5
  resp_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (response_o != RESP_OKAY) |-> (MODE == ERR_BUSERR && errant_i && !waitrequest_o));

  // R6
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((read_i || write_i) && errant_i));

  // R7
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(write_i && !waitrequest_o && address_i == CLR_ADDR && clr_bit_i));

  // R8
  rst_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> (run_q >= RST_MIN_W));

  // R11
  irq_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (MODE == ERR_IRQ));

  // R11
  rst_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (MODE == ERR_RESET));

endmodule

bind errant_slave errant_slave_chk #(
  .ADDR_W   (ADDR_W),
  .MODE     (MODE),
  .OWN_BASE (OWN_BASE),
  .RST_MIN_W(RST_MIN_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .address_i    (address_i),
  .read_i       (read_i),
  .write_i      (write_i),
  .clr_bit_i    (writedata_i[0]),
  .errant_i     (errant),
  .waitrequest_o(waitrequest_o),
  .response_o   (response_o),
  .irq_o        (irq_o),
  .rst_req_o    (rst_req_o)
);

// File: tb/sim_errant_slave.sv
module sim_errant_slave;
  import errant_pkg::*;

  localparam int          AW   = 12;
  localparam int          DW   = 32;
  localparam logic [31:0] PAT  = 32'h0BAD_F00D;
  localparam logic [11:0] BASE = 12'h100;
  localparam int          MINW = 5;
  localparam int          NDUT = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] addr [NDUT];
  logic          rd_s [NDUT];
  logic          wr_s [NDUT];
  logic [DW-1:0] wdat [NDUT];
  logic [DW-1:0] rdata [NDUT];
  logic          wreq [NDUT];
  logic [1:0]    resp [NDUT];
  logic          irq  [NDUT];
  logic          rstq [NDUT];

  for (genvar g = 0; g < NDUT; g++) begin : gen_dut
    errant_slave #(
      .ADDR_W   (AW),
      .DATA_W   (DW),
      .MODE     (err_mode_e'(g)),
      .PATTERN  (PAT),
      .OWN_BASE (BASE),
      .RST_MIN_W(MINW)
    ) u0 (
      .clk_i        (clk),
      .rst_ni       (rst_ni),
      .address_i    (addr[g]),
      .read_i       (rd_s[g]),
      .write_i      (wr_s[g]),
      .writedata_i  (wdat[g]),
      .readdata_o   (rdata[g]),
      .waitrequest_o(wreq[g]),
      .response_o   (resp[g]),
      .irq_o        (irq[g]),
      .rst_req_o    (rstq[g])
    );
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input int d, input logic w, input logic [11:0] a, input logic [31:0] wd,
                      output logic w0, output logic w1, output logic [31:0] rdv,
                      output logic [1:0] rs, output logic iq, output logic rq);
    @(negedge clk);
    addr[d] = a; wr_s[d] = w; rd_s[d] = !w; wdat[d] = wd;
    #1 w0 = wreq[d];
    @(negedge clk);
    #1;
    w1 = wreq[d]; rdv = rdata[d]; rs = resp[d]; iq = irq[d]; rq = rstq[d];
    @(negedge clk);
    wr_s[d] = 1'b0; rd_s[d] = 1'b0;
  endtask

  typedef struct packed {
    logic [2:0]  dut;
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [31:0] exp_rd;
    logic [1:0]  exp_rs;
    logic        exp_irq;
    logic        exp_rst;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VEC [NVEC] = '{
    '{3'd1, 1'b0, 12'h040, 32'h0,        PAT,          2'b00, 1'b0, 1'b0}, // R4
    '{3'd1, 1'b1, 12'h041, 32'hFFFF_FFFF, 32'h0,       2'b00, 1'b0, 1'b0}, // R2 write discarded
    '{3'd1, 1'b0, 12'h100, 32'h0,        32'h041,      2'b00, 1'b0, 1'b0}, // R9 R1
    '{3'd1, 1'b0, 12'h0FF, 32'h0,        PAT,          2'b00, 1'b0, 1'b0}, // R4 below span
    '{3'd1, 1'b0, 12'h102, 32'h0,        PAT,          2'b00, 1'b0, 1'b0}, // R4 above span
    '{3'd2, 1'b0, 12'h200, 32'h0,        32'h0,        2'b11, 1'b0, 1'b0}, // R5 read
    '{3'd2, 1'b1, 12'h201, 32'h1234,     32'h0,        2'b11, 1'b0, 1'b0}, // R5 write
    '{3'd2, 1'b0, 12'h100, 32'h0,        32'h201,      2'b00, 1'b0, 1'b0}, // R1 R5
    '{3'd3, 1'b0, 12'h300, 32'h0,        32'h0,        2'b00, 1'b1, 1'b0}, // R6
    '{3'd3, 1'b0, 12'h101, 32'h0,        32'h1,        2'b00, 1'b1, 1'b0}, // R7 readback
    '{3'd3, 1'b1, 12'h101, 32'h0,        32'h0,        2'b00, 1'b1, 1'b0}, // R7 bit0 low
    '{3'd3, 1'b0, 12'h101, 32'h0,        32'h1,        2'b00, 1'b1, 1'b0}, // R7 still set
    '{3'd3, 1'b1, 12'h101, 32'h1,        32'h0,        2'b00, 1'b1, 1'b0}, // R7 clear
    '{3'd3, 1'b0, 12'h101, 32'h0,        32'h0,        2'b00, 1'b0, 1'b0}, // R7 cleared
    '{3'd3, 1'b0, 12'h100, 32'h0,        32'h300,      2'b00, 1'b0, 1'b0}, // R9
    '{3'd4, 1'b0, 12'h7FF, 32'h0,        32'h0,        2'b00, 1'b0, 1'b1}, // R8 R11
    '{3'd4, 1'b0, 12'h100, 32'h0,        32'h7FF,      2'b00, 1'b0, 1'b1}, // R8 pulse ongoing
    '{3'd4, 1'b1, 12'h100, 32'hABC,      32'h0,        2'b00, 1'b0, 1'b0}, // R8 pulse over
    '{3'd4, 1'b0, 12'h100, 32'h0,        32'h7FF,      2'b00, 1'b0, 1'b0}, // R9 status write ignored
    '{3'd0, 1'b0, 12'h100, 32'h0,        32'h0,        2'b00, 1'b0, 1'b0}  // R10 R1 hang status
  };

  bit done_flag = 1'b0;

  initial begin
    #(8 * 100000);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL R0 watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic w0, w1, iq, rq;
    logic [31:0] rdv;
    logic [1:0]  rs;
    int n;
    bit run;

    for (int i = 0; i < NDUT; i++) begin
      addr[i] = '0; rd_s[i] = 1'b0; wr_s[i] = 1'b0; wdat[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #1;
    // R10 reset state
    for (int i = 0; i < NDUT; i++) begin
      chk(!wreq[i] && resp[i] == 2'b00 && rdata[i] == '0, "R10 idle bus",
          {wreq[i], resp[i], rdata[i][28:0]}, 32'h0);
      chk(!irq[i] && !rstq[i], "R10 irq/rst", {irq[i], rstq[i]}, 32'h0);
    end

    for (int v = 0; v < NVEC; v++) begin
      xfer(int'(VEC[v].dut), VEC[v].wr, VEC[v].addr, VEC[v].wd, w0, w1, rdv, rs, iq, rq);
      chk(w0 == 1'b1, "R2 wait cycle", w0, 1);
      chk(w1 == 1'b0, "R2 completion", w1, 0);
      chk(rdv == VEC[v].exp_rd, "R1/R4/R9 readdata", rdv, VEC[v].exp_rd);
      chk(rs == VEC[v].exp_rs, "R5 response", rs, VEC[v].exp_rs);
      chk(iq == VEC[v].exp_irq, "R6/R7/R11 irq", iq, VEC[v].exp_irq);
      chk(rq == VEC[v].exp_rst, "R8/R11 rst_req", rq, VEC[v].exp_rst);
    end

    // R8 full width: after return, MINW-1 high cycles remain
    xfer(4, 1'b0, 12'h055, 32'h0, w0, w1, rdv, rs, iq, rq);
    chk(rq == 1'b1, "R8 pulse start", rq, 1);
    n = 0; run = 1'b1;
    for (int i = 0; i < 12; i++) begin
      #1 if (run && rstq[4]) n++; else run = 1'b0;
      @(negedge clk);
    end
    chk(n == MINW - 1, "R8 width", n, MINW - 1);

    // R8 restart: second trigger while pulse running
    xfer(4, 1'b0, 12'h056, 32'h0, w0, w1, rdv, rs, iq, rq);
    xfer(4, 1'b0, 12'h057, 32'h0, w0, w1, rdv, rs, iq, rq);
    n = 0; run = 1'b1;
    for (int i = 0; i < 12; i++) begin
      #1 if (run && rstq[4]) n++; else run = 1'b0;
      @(negedge clk);
    end
    chk(n == MINW - 1, "R8 restart width", n, MINW - 1);

    // R3 hang: stall persists
    @(negedge clk);
    addr[0] = 12'h055; rd_s[0] = 1'b1;
    n = 0;
    for (int i = 0; i < 30; i++) begin
      #1 if (!wreq[0] || irq[0] || rstq[0]) n++;
      @(negedge clk);
    end
    chk(n == 0, "R3 stall held", n, 0);
    rd_s[0] = 1'b0;
    // R9 hang capture
    xfer(0, 1'b0, BASE, 32'h0, w0, w1, rdv, rs, iq, rq);
    chk(rdv == 32'h055 && !w1, "R9 hang capture", rdv, 32'h055);

    // R10 reset clears state
    xfer(3, 1'b0, 12'h333, 32'h0, w0, w1, rdv, rs, iq, rq);
    chk(iq == 1'b1, "R6 irq set", iq, 1);
    xfer(4, 1'b0, 12'h444, 32'h0, w0, w1, rdv, rs, iq, rq);
    @(negedge clk);
    addr[0] = 12'h066; rd_s[0] = 1'b1;
    @(negedge clk);
    rst_ni = 1'b0;
    rd_s[0] = 1'b0;
    #1;
    chk(!irq[3] && !rstq[4], "R10 outputs cleared", {irq[3], rstq[4]}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    xfer(0, 1'b0, BASE, 32'h0, w0, w1, rdv, rs, iq, rq);
    chk(rdv == 32'h0 && !w1, "R10 capture cleared", rdv, 0);
    xfer(3, 1'b0, BASE + 12'h1, 32'h0, w0, w1, rdv, rs, iq, rq);
    chk(rdv == 32'h0, "R10 irq readback", rdv, 0);
    xfer(4, 1'b0, BASE, 32'h0, w0, w1, rdv, rs, iq, rq);
    chk(rdv == 32'h0, "R10 reset-mode capture", rdv, 0);

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule